// File: doc/BRIEF.md
# Sort, Trap and Shuffle Stage for a Self-Routing Fabric

This stage sits in front of an 8-port banyan fabric. On every clock it takes up to eight requests, each a valid flag and a 3-bit destination address. It puts them in ascending address order with an odd-even merge network built from 2x2 compare-exchange cells. It keeps one request per destination and moves the survivors down to the lowest positions with no holes between them. It then applies a perfect shuffle, so that the fabric behind it can route the result without internal collisions.

Each output port carries the address and the original input index of the request placed there. Requests that lost to an earlier request for the same address are not forwarded. Instead they are reported as a mask over the input indices, so that the surrounding logic can hold them for a later slot. The whole path is combinational and ends in a single register, so a result appears one clock after its inputs are sampled.

Top module: `batcherTrap`

## Requirements
- R1: While `rst_n` is low, `outValid`, `outAddr`, `outSrc` and `trapMask` are all zero, whatever the inputs are.
- R2: The outputs change only at a rising clock edge. They show the result for the inputs sampled at the most recent rising edge.
- R3: The number of set bits in `outValid` equals the number of distinct addresses among the valid inputs.
- R4: When several valid inputs share an address, the one with the lowest input index is forwarded, and `outSrc` at its port holds that index.
- R5: Bit j of `trapMask` is 1 exactly when input j is valid and some valid input with a smaller index has the same address.
- R6: Number the forwarded requests m = 0, 1, ... in strictly ascending address order. Request m appears at output port q, where q is m rotated left by one bit (q = {m[1:0], m[2]}). Port q's fields are `outAddr[3q+2:3q]` and `outSrc[3q+2:3q]`.
- R7: An output port with `outValid` low shows zero on its address and source fields.
- R8: The address of an input whose valid flag is low has no effect on any output.
- R9: Every valid input is either forwarded or trapped, never both. So the sum of the popcounts of `outValid` and `trapMask` equals the popcount of the sampled `inValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 8 | Request present on input j (bit j) |
| inAddr | input | 24 | Destination of input j in bits [3j+2:3j] |
| outValid | output | 8 | Port q carries a forwarded request |
| outAddr | output | 24 | Destination at port q in bits [3q+2:3q] |
| outSrc | output | 24 | Original input index at port q in bits [3q+2:3q] |
| trapMask | output | 8 | Input j was dropped as a duplicate |

## Verification
A misplaced compare-exchange cell or a wrong merge partner shows up one clock later. The survivors then come out of address order after the shuffle is undone, or a duplicate slips through beside its twin. A bad survivor count or tie rule breaks the balance between forwarded and trapped requests, or swaps which input index is reported, on the very next output. The bench sweeps all 256 valid masks against several address patterns: all equal, all distinct in both orders, and mixed. It also covers the worked example of three requests on two addresses, so every mistake of this kind surfaces within one cycle of the vector that provokes it.

// File: rtl/batcherTrap_pkg.sv
package batcherTrap_pkg;
  parameter int LOG_N = 3;
  localparam int N      = 1 << LOG_N;
  localparam int KEY_W  = 1 + 2 * LOG_N;
  localparam int LAYERS = LOG_N * (LOG_N + 1) / 2;

  typedef logic [KEY_W-1:0] key_t;

  // strobes from the trap control to the datapath, one set per sorted lane
  typedef struct packed {
    logic [N-1:0]            keep;
    logic [N-1:0][LOG_N-1:0] slot;
  } trapStrobe_t;

  // partner lane of lane w in compare layer s of the odd-even merge sort, -1 if idle
  function automatic int cePartner(int s, int w);
    int layer;
    int res;
    layer = 0;
    res = -1;
    for (int p = 1; p < N; p = p * 2) begin
      for (int k = p; k >= 1; k = k / 2) begin
        if (layer == s) begin
          for (int j = k % p; j + k < N; j = j + 2 * k) begin
            for (int i = 0; i < k; i++) begin
              if ((i + j + k < N) && (((i + j) / (2 * p)) == ((i + j + k) / (2 * p)))) begin
                if (i + j == w) res = i + j + k;
                if (i + j + k == w) res = i + j;
              end
            end
          end
        end
        layer++;
      end
    end
    return res;
  endfunction

  function automatic logic [LOG_N-1:0] rotl1(logic [LOG_N-1:0] m);
    return {m[LOG_N-2:0], m[LOG_N-1]};
  endfunction
endpackage

// File: rtl/cmpEx.sv
module cmpEx #(
  parameter int W = 7
) (
  input  logic [W-1:0] keyA,
  input  logic [W-1:0] keyB,
  output logic [W-1:0] keyLo,
  output logic [W-1:0] keyHi
);
  logic swap;
  assign swap  = keyA > keyB;
  assign keyLo = swap ? keyB : keyA;
  assign keyHi = swap ? keyA : keyB;
endmodule

// File: rtl/trapCtrl.sv
module trapCtrl
  import batcherTrap_pkg::*;
(
  input  logic [N-1:0][KEY_W-1:0] sortKey,
  output trapStrobe_t             strobe
);
  logic [LOG_N:0] runCount;
  logic           laneValid;
  logic           prevValid;
  logic           sameAddr;

  always_comb begin
    strobe   = '0;
    runCount = '0;
    prevValid = 1'b0;
    for (int i = 0; i < N; i++) begin
      laneValid = ~sortKey[i][KEY_W-1];
      if (i > 0) begin
        prevValid = ~sortKey[i-1][KEY_W-1];
        sameAddr  = sortKey[i][KEY_W-2 -: LOG_N] == sortKey[i-1][KEY_W-2 -: LOG_N];
      end else begin
        prevValid = 1'b0;
        sameAddr  = 1'b0;
      end
      strobe.keep[i] = laneValid && !(prevValid && sameAddr);
      strobe.slot[i] = runCount[LOG_N-1:0];
      runCount = runCount + {{LOG_N{1'b0}}, strobe.keep[i]};
    end
  end
endmodule

// File: rtl/sortPath.sv
module sortPath
  import batcherTrap_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            inValid,
  input  logic [N*LOG_N-1:0]      inAddr,
  input  trapStrobe_t             strobe,
  output logic [N-1:0][KEY_W-1:0] sortKey,
  output logic [N-1:0]            outValid,
  output logic [N*LOG_N-1:0]      outAddr,
  output logic [N*LOG_N-1:0]      outSrc,
  output logic [N-1:0]            trapMask
);
  key_t stg [0:LAYERS][0:N-1];

  genvar s, w;
  generate
    for (w = 0; w < N; w++) begin : g_load
      localparam logic [LOG_N-1:0] IDX = LOG_N'(w);
      assign stg[0][w] = {~inValid[w],
                          inValid[w] ? inAddr[w*LOG_N +: LOG_N] : {LOG_N{1'b0}},
                          IDX};
      assign sortKey[w] = stg[LAYERS][w];
    end
    for (s = 0; s < LAYERS; s++) begin : g_layer
      for (w = 0; w < N; w++) begin : g_lane
        localparam int PT = cePartner(s, w);
        if (PT < 0) begin : g_pass
          assign stg[s+1][w] = stg[s][w];
        end else if (PT > w) begin : g_cell
          cmpEx #(.W(KEY_W)) u_cell (
            .keyA (stg[s][w]),
            .keyB (stg[s][PT]),
            .keyLo(stg[s+1][w]),
            .keyHi(stg[s+1][PT])
          );
        end
      end
    end
  endgenerate

  logic [N-1:0]       nextValid;
  logic [N*LOG_N-1:0] nextAddr;
  logic [N*LOG_N-1:0] nextSrc;
  logic [N-1:0]       nextTrap;
  logic [LOG_N-1:0]   port;

  always_comb begin
    nextValid = '0;
    nextAddr  = '0;
    nextSrc   = '0;
    nextTrap  = '0;
    port      = '0;
    for (int i = 0; i < N; i++) begin
      if (strobe.keep[i]) begin
        port = rotl1(strobe.slot[i]);
        nextValid[port] = 1'b1;
        nextAddr[port*LOG_N +: LOG_N] = sortKey[i][KEY_W-2 -: LOG_N];
        nextSrc[port*LOG_N +: LOG_N]  = sortKey[i][LOG_N-1:0];
      end else if (!sortKey[i][KEY_W-1]) begin
        nextTrap[sortKey[i][LOG_N-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= '0;
      outAddr  <= '0;
      outSrc   <= '0;
      trapMask <= '0;
    end else begin
      outValid <= nextValid;
      outAddr  <= nextAddr;
      outSrc   <= nextSrc;
      trapMask <= nextTrap;
    end
  end
endmodule

// File: rtl/batcherTrap.sv
module batcherTrap
  import batcherTrap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       inValid,
  input  logic [N*LOG_N-1:0] inAddr,
  output logic [N-1:0]       outValid,
  output logic [N*LOG_N-1:0] outAddr,
  output logic [N*LOG_N-1:0] outSrc,
  output logic [N-1:0]       trapMask
);
  logic [N-1:0][KEY_W-1:0] sortKey;
  trapStrobe_t             strobe;

  sortPath u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inAddr  (inAddr),
    .strobe  (strobe),
    .sortKey (sortKey),
    .outValid(outValid),
    .outAddr (outAddr),
    .outSrc  (outSrc),
    .trapMask(trapMask)
  );

  trapCtrl u_ctrl (
    .sortKey(sortKey),
    .strobe (strobe)
  );
endmodule

// File: rtl/batcherTrap_chk.sv
module batcherTrap_chk
  import batcherTrap_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       inValid,
  input logic [N*LOG_N-1:0] inAddr,
  input logic [N-1:0]       outValid,
  input logic [N*LOG_N-1:0] outAddr,
  input logic [N*LOG_N-1:0] outSrc,
  input logic [N-1:0]       trapMask
);
  // occupancy in forwarding order (shuffle undone)
  function automatic logic [N-1:0] unshuf(logic [N-1:0] v);
    logic [N-1:0] c;
    for (int m = 0; m < N; m++) c[m] = v[rotl1(LOG_N'(m))];
    return c;
  endfunction

  function automatic logic ascendOk(logic [N-1:0] v, logic [N*LOG_N-1:0] a);
    logic ok;
    logic [LOG_N-1:0] q0, q1;
    ok = 1'b1;
    for (int m = 0; m < N - 1; m++) begin
      q0 = rotl1(LOG_N'(m));
      q1 = rotl1(LOG_N'(m + 1));
      if (v[q1] && !(a[q1*LOG_N +: LOG_N] > a[q0*LOG_N +: LOG_N])) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic idleOk(logic [N-1:0] v, logic [N*LOG_N-1:0] a, logic [N*LOG_N-1:0] sr);
    logic ok;
    ok = 1'b1;
    for (int q = 0; q < N; q++)
      if (!v[q] && (a[q*LOG_N +: LOG_N] != '0 || sr[q*LOG_N +: LOG_N] != '0)) ok = 1'b0;
    return ok;
  endfunction

  logic [N-1:0] compOcc;
  assign compOcc = unshuf(outValid);

  p_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(outValid) + $countones(trapMask)) == $countones($past(inValid)));

  p_trap_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (trapMask & ~$past(inValid)) == '0);

  p_lowest_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trapMask[0]);

  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (compOcc & (compOcc + 1'b1)) == '0);

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ascendOk(outValid, outAddr));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idleOk(outValid, outAddr, outSrc));
endmodule

bind batcherTrap batcherTrap_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .inAddr  (inAddr),
  .outValid(outValid),
  .outAddr (outAddr),
  .outSrc  (outSrc),
  .trapMask(trapMask)
);

// File: tb/batcherTrap_bench.sv
module batcherTrap_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  inValid;
  logic [23:0] inAddr;
  logic [7:0]  outValid;
  logic [23:0] outAddr;
  logic [23:0] outSrc;
  logic [7:0]  trapMask;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0]  expV, prevV;
  logic [23:0] expA, expS, prevA, prevS;
  logic [7:0]  expT, prevT;
  int          expCount;

  always #2.5 clk = ~clk;

  batcherTrap u_batcherTrap (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outAddr(outAddr), .outSrc(outSrc), .trapMask(trapMask)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model from the requirements
  task automatic model();
    bit surv [8];
    int rank;
    int q;
    expV = '0; expA = '0; expS = '0; expT = '0; expCount = 0;
    for (int j = 0; j < 8; j++) begin
      surv[j] = inValid[j];
      for (int k = 0; k < j; k++)
        if (inValid[j] && inValid[k] && inAddr[3*k +: 3] == inAddr[3*j +: 3]) surv[j] = 0;
      if (inValid[j] && !surv[j]) expT[j] = 1'b1;
    end
    for (int j = 0; j < 8; j++) begin
      if (surv[j]) begin
        expCount++;
        rank = 0;
        for (int k = 0; k < 8; k++)
          if (surv[k] && inAddr[3*k +: 3] < inAddr[3*j +: 3]) rank++;
        q = ((rank << 1) | (rank >> 2)) & 7;
        expV[q] = 1'b1;
        expA[3*q +: 3] = inAddr[3*j +: 3];
        expS[3*q +: 3] = 3'(j);
      end
    end
  endtask

  task automatic applyVec(input logic [7:0] v, input logic [23:0] a);
    prevV = expV; prevA = expA; prevS = expS; prevT = expT;
    inValid = v;
    inAddr  = a;
    model();
    #1;
    check(outValid == prevV && outAddr == prevA && outSrc == prevS && trapMask == prevT,
          "R2 hold before edge", {24'd0, outValid}, {24'd0, prevV});
    @(negedge clk);
    check(outValid == expV && outAddr == expA, "R6 placement", {outValid, outAddr}, {expV, expA});
    check(outSrc == expS, "R4 source index", {8'd0, outSrc}, {8'd0, expS});
    check(trapMask == expT, "R5 trap mask", {24'd0, trapMask}, {24'd0, expT});
    check($countones(outValid) == expCount, "R3 distinct count", $countones(outValid), expCount);
  endtask

  initial begin
    logic [23:0] a;
    logic [23:0] a2;
    int seed;
    rst_n = 1'b1;
    inValid = 8'hFF;
    inAddr = 24'hFAC688;
    expV = '0; expA = '0; expS = '0; expT = '0;
    #1 rst_n = 1'b0;
    #3;
    check(outValid == 0 && outAddr == 0 && outSrc == 0 && trapMask == 0, "R1 reset clear",
          {24'd0, outValid}, 32'd0);
    @(negedge clk);
    #0.5;
    check(outValid == 0 && trapMask == 0, "R1 reset clear with inputs", {24'd0, outValid}, 32'd0);
    rst_n = 1'b1;
    inValid = 0;
    @(negedge clk);

    // worked example: inputs 1,2,4 valid with addresses 3,2,3
    applyVec(8'b0001_0110, {3'd0, 3'd0, 3'd0, 3'd3, 3'd0, 3'd2, 3'd3, 3'd0});
    check(outValid == 8'b0000_0101, "R6 example ports", {24'd0, outValid}, 32'h05);
    check(outAddr[5:3] == 3'd0 && outAddr[8:6] == 3'd3 && outSrc[8:6] == 3'd1, "R4 example port2",
          {20'd0, outAddr[8:6], 3'd0, outSrc[8:6]}, {20'd0, 3'd3, 3'd0, 3'd1});
    check(trapMask == 8'b0001_0000, "R5 example trap", {24'd0, trapMask}, 32'h10);
    check(outAddr[23:9] == 0 && outSrc[23:9] == 0 && outAddr[5:3] == 0, "R7 idle ports zero",
          {17'd0, outAddr[23:9]}, 32'd0);

    // same valid mask, different addresses on idle inputs: no change
    applyVec(8'b0001_0110, {3'd7, 3'd5, 3'd1, 3'd3, 3'd6, 3'd2, 3'd3, 3'd4});
    check(outValid == 8'b0000_0101 && outSrc[2:0] == 3'd2, "R8 idle address ignored",
          {24'd0, outValid}, 32'h05);

    // all valid, all on one address
    applyVec(8'hFF, {8{3'd5}});
    check(outValid == 8'h01 && trapMask == 8'hFE && outSrc[2:0] == 0, "R9 all same address",
          {16'd0, outValid, trapMask}, {16'd0, 8'h01, 8'hFE});

    // sweep every valid mask against several address patterns
    for (int mask = 0; mask < 256; mask++) begin
      for (int pat = 0; pat < 8; pat++) begin
        seed = mask * 13 + pat * 7 + 1;
        for (int j = 0; j < 8; j++) begin
          case (pat)
            0: a[3*j +: 3] = 3'(mask);
            1: a[3*j +: 3] = 3'(j);
            2: a[3*j +: 3] = 3'(7 - j);
            3: a[3*j +: 3] = 3'(j / 2);
            default: a[3*j +: 3] = 3'((seed * (j + 3) + j * j * pat) >> 1);
          endcase
        end
        applyVec(8'(mask), a);
        check($countones(outValid) + $countones(trapMask) == $countones(8'(mask)), "R9 conservation",
              $countones(outValid) + $countones(trapMask), $countones(8'(mask)));
        check(((outValid == 0) || (outValid[0] == 1'b1)) && (~outValid & expV) == 0,
              "R7 occupancy", {24'd0, outValid}, {24'd0, expV});
        if (pat == 4) begin
          a2 = a;
          for (int j = 0; j < 8; j++) if (!mask[j]) a2[3*j +: 3] = ~a[3*j +: 3];
          applyVec(8'(mask), a2);
          check(outValid == expV, "R8 idle address ignored", {24'd0, outValid}, {24'd0, expV});
        end
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule